// File: doc/BRIEF.md
# MMU control and fault register block

This block is the software-visible face of a system MMU. It sits on a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. From the bus it drives the translation datapath: a translation enable, a stall request, single-cycle flush pulses for the whole TLB or for one page, the page-table base, a configuration word and two prefetch address windows. From the datapath it takes a drain-done indication and fault events. Each fault event carries a type code and the address that failed.

A four-state machine governs the datapath. The states are ST_OFF (translation disabled), ST_RUN (translating), ST_DRAIN (stall requested, waiting for the datapath to empty) and ST_HELD (stalled and drained). Its transitions are as follows:
- ST_OFF goes to ST_RUN on an enable command.
- ST_RUN goes to ST_DRAIN on a hold command or on any fault.
- ST_DRAIN goes to ST_HELD when drain-done is sampled high.
- ST_DRAIN or ST_HELD goes back to ST_RUN on an enable command in a cycle with no fault.
- Any state goes to ST_OFF on a disable command, and this command overrides every other cause.

Software requests a stall, then polls the held flag before it changes tables or flushes. A fault stalls the datapath by itself and raises an interrupt. Each fault type keeps its own pending bit, so software can see which kinds of fault are waiting and can clear them one at a time.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset the following hold. The mode register (0x000) reads 0 and the held register (0x008) reads 0. The pending register (0x018) reads 0 and the mask register (0x020) reads 0x000000FF. The version register (0x034) reads the major version 3 in bits [31:28] and zero below them. The outputs xlat_en_o, stall_o and irq_o are low.
- R2: A write of 0x5 to 0x000 from ST_OFF raises xlat_en_o, and the mode register then reads 0x5. A write of 0x0 goes to ST_OFF from any state and wins over faults and other causes in the same cycle. Any other written value leaves the state unchanged.
- R3: A write of 0x7 to 0x000 in ST_RUN raises stall_o on the next cycle, and the mode register then reads 0x7. Bit 0 of 0x008 stays 0 until drain_done_i has been sampled high at a clock edge in ST_DRAIN, and reads 1 from the cycle after that edge.
- R4: A write of 0x5 in ST_DRAIN or ST_HELD, with no fault in the same cycle, lowers stall_o and clears bit 0 of 0x008, while xlat_en_o stays high.
- R5: A fault event in ST_RUN moves to ST_DRAIN, so stall_o rises on the next cycle. A fault in the same cycle as a write of 0x5 in ST_DRAIN keeps the stall.
- R6: A fault event writes its address into the register for its class. Type 0 (page fault) goes to 0x024. Types 2, 6 and 7 (write-side) go to 0x028. Types 1, 4 and 5 (read-side) go to 0x02C. Type 3 (bus error) goes to 0x030.
- R7: A fault of type t sets bit t of the pending register 0x018. A write to 0x01C clears each pending bit whose data bit is 1. If a fault and a clear of the same bit arrive in the same cycle, the bit stays set.
- R8: irq_o is high exactly when some pending bit is set and the matching bit of the mask register 0x020 (bits [7:0]) is also set.
- R9: While irq_o is high, irq_type_o is the index of the lowest-numbered bit that is both pending and enabled in the mask.
- R10: A write to 0x00C with data bit 0 set gives a one-cycle pulse on flush_all_o in the cycle after the write. A write to 0x010 with data bit 0 set gives a one-cycle pulse on flush_one_o, with flush_addr_o equal to the written data with bits [11:0] cleared. A write with bit 0 clear gives no pulse.
- R11: The configuration register (0x004) and the table-base register (0x014) read back what was written and drive cfg_o and table_base_o.
- R12: With version 3, window 0 has its start register at 0x04C and its inclusive end register at 0x050, and window 1 has them at 0x054 and 0x058. All four read back what was written and drive the matching 32-bit slice of pfw_start_o or pfw_end_o.
- R13: A fault event in ST_OFF is still recorded in the pending bits and the address registers, but it does not raise stall_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| drain_done_i | input | 1 | Datapath reports it has emptied |
| xlat_en_o | output | 1 | Translation enabled |
| stall_o | output | 1 | Datapath must stop accepting requests |
| flush_all_o | output | 1 | One-cycle full TLB flush |
| flush_one_o | output | 1 | One-cycle single-page flush |
| flush_addr_o | output | 32 | Page address for flush_one_o |
| table_base_o | output | 32 | Page-table base address |
| cfg_o | output | 32 | Configuration word |
| fault_valid_i | input | 1 | Fault event strobe |
| fault_type_i | input | 3 | Fault type code 0..7 |
| fault_addr_i | input | 32 | Address that faulted |
| irq_o | output | 1 | Interrupt request |
| irq_type_o | output | 3 | Lowest pending enabled fault type |
| pfw_start_o | output | 64 | Prefetch window start addresses, window 0 in bits [31:0] |
| pfw_end_o | output | 64 | Prefetch window inclusive end addresses, window 0 in bits [31:0] |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a fault arriving together with an enable command while draining. Another is a fault arriving together with a write-one-to-clear of the same bit. A third is the exact cycle in which the held flag may first read 1. The directed part of the stimulus drives the write strobe and the fault strobe in the same cycle. It also raises drain-done and samples the held flag both before and after the edge that takes it in. A seeded random phase then mixes faults of every type, partial clears and mask changes, and compares the interrupt, the reported type, the pending bits and the four address registers against a reference model in the bench.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HELD  = 2'd3
    } mmu_state_e;

    localparam int OFS_MODE      = 'h000;
    localparam int OFS_CFG       = 'h004;
    localparam int OFS_HELD      = 'h008;
    localparam int OFS_FLUSH_ALL = 'h00C;
    localparam int OFS_FLUSH_ONE = 'h010;
    localparam int OFS_BASE      = 'h014;
    localparam int OFS_PEND      = 'h018;
    localparam int OFS_PEND_CLR  = 'h01C;
    localparam int OFS_MASK      = 'h020;
    localparam int OFS_FADDR0    = 'h024;
    localparam int OFS_VERSION   = 'h034;
    localparam int OFS_WIN0      = 'h04C;
    localparam int WIN_STRIDE    = 8;

    localparam int CMD_OFF  = 'h0;
    localparam int CMD_RUN  = 'h5;
    localparam int CMD_HOLD = 'h7;

    localparam int NSLOT     = 4;
    localparam int SLOT_PAGE = 0;
    localparam int SLOT_WR   = 1;
    localparam int SLOT_RD   = 2;
    localparam int SLOT_BUS  = 3;

    function automatic logic [1:0] fault_slot(input logic [2:0] t);
        case (t)
            3'd0:              return 2'(SLOT_PAGE);
            3'd3:              return 2'(SLOT_BUS);
            3'd1, 3'd4, 3'd5:  return 2'(SLOT_RD);
            default:           return 2'(SLOT_WR);
        endcase
    endfunction

endpackage

// File: rtl/mmu_ctl_fsm.sv
module mmu_ctl_fsm
    import mmu_ctl_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       go_run_i,
    input  logic       go_hold_i,
    input  logic       go_off_i,
    input  logic       fault_i,
    input  logic       drain_done_i,
    output mmu_state_e state_o,
    output logic       xlat_en_o,
    output logic       stall_o,
    output logic       held_o
);

    mmu_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (go_run_i) state_d = ST_RUN;
            ST_RUN:   if (fault_i || go_hold_i) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (go_run_i && !fault_i) state_d = ST_RUN;
                else if (drain_done_i)    state_d = ST_HELD;
            end
            ST_HELD:  if (go_run_i && !fault_i) state_d = ST_RUN;
        endcase
        if (go_off_i) state_d = ST_OFF;
    end

    always_comb begin
        state_o   = state_q;
        xlat_en_o = (state_q != ST_OFF);
        stall_o   = (state_q == ST_DRAIN) || (state_q == ST_HELD);
        held_o    = (state_q == ST_HELD);
    end

    AST_HELD_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(held_o) |-> $past(drain_done_i)); // R3
    AST_OFF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_off_i |=> (!xlat_en_o && !stall_o)); // R2
    AST_FAULT_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_i && xlat_en_o && !go_off_i) |=> stall_o); // R5
    AST_RUN_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_run_i && !fault_i && !go_off_i && stall_o) |=> (!stall_o && xlat_en_o)); // R4

endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
    import mmu_ctl_pkg::*;
#(
    parameter int NFAULT = 8,
    parameter int DW     = 32,
    localparam int TW    = $clog2(NFAULT)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        fault_v_i,
    input  logic [TW-1:0]               fault_type_i,
    input  logic [DW-1:0]               fault_addr_i,
    input  logic                        clr_we_i,
    input  logic [NFAULT-1:0]           clr_bits_i,
    input  logic [NFAULT-1:0]           mask_i,
    output logic [NFAULT-1:0]           status_o,
    output logic [NSLOT-1:0][DW-1:0]    slot_addr_o,
    output logic                        irq_o,
    output logic [TW-1:0]               irq_type_o
);

    logic [NFAULT-1:0]        status_q, set_v, clr_v, pend;
    logic [NSLOT-1:0][DW-1:0] slot_q;

    always_comb begin
        set_v = fault_v_i ? (NFAULT'(1) << fault_type_i) : '0;
        clr_v = clr_we_i ? clr_bits_i : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
            slot_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_v) | set_v;
            if (fault_v_i) slot_q[fault_slot(fault_type_i)] <= fault_addr_i;
        end
    end

    always_comb begin
        pend       = status_q & mask_i;
        irq_type_o = '0;
        for (int i = NFAULT - 1; i >= 0; i--) begin
            if (pend[i]) irq_type_o = TW'(i);
        end
        irq_o       = |pend;
        status_o    = status_q;
        slot_addr_o = slot_q;
    end

    AST_FAULT_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_v_i |=> status_o[$past(fault_type_i)]); // R7
    AST_SLOT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_v_i |=> (slot_addr_o[fault_slot($past(fault_type_i))] == $past(fault_addr_i))); // R6
    AST_IRQ_TYPE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_o[irq_type_o] && mask_i[irq_type_o])); // R9

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int NFAULT     = 8,
    parameter int VER_MAJOR  = 3,
    parameter int NWIN       = 2,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [AW-1:0]              reg_addr_i,
    input  logic                       reg_we_i,
    input  logic [DW-1:0]              reg_wdata_i,
    output logic [DW-1:0]              reg_rdata_o,
    input  logic                       drain_done_i,
    output logic                       xlat_en_o,
    output logic                       stall_o,
    output logic                       flush_all_o,
    output logic                       flush_one_o,
    output logic [DW-1:0]              flush_addr_o,
    output logic [DW-1:0]              table_base_o,
    output logic [DW-1:0]              cfg_o,
    input  logic                       fault_valid_i,
    input  logic [$clog2(NFAULT)-1:0]  fault_type_i,
    input  logic [DW-1:0]              fault_addr_i,
    output logic                       irq_o,
    output logic [$clog2(NFAULT)-1:0]  irq_type_o,
    output logic [NWIN*DW-1:0]         pfw_start_o,
    output logic [NWIN*DW-1:0]         pfw_end_o
);

    localparam bit HAS_WIN = (VER_MAJOR == 3);

    function automatic logic hit(input logic [AW-1:0] a, input int ofs);
        return a == AW'(ofs);
    endfunction

    logic go_run, go_hold, go_off, clr_we;
    always_comb begin
        go_run  = reg_we_i && hit(reg_addr_i, OFS_MODE) && (reg_wdata_i == DW'(CMD_RUN));
        go_hold = reg_we_i && hit(reg_addr_i, OFS_MODE) && (reg_wdata_i == DW'(CMD_HOLD));
        go_off  = reg_we_i && hit(reg_addr_i, OFS_MODE) && (reg_wdata_i == DW'(CMD_OFF));
        clr_we  = reg_we_i && hit(reg_addr_i, OFS_PEND_CLR);
    end

    mmu_state_e state;
    logic       held;

    mmu_ctl_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .go_run_i     (go_run),
        .go_hold_i    (go_hold),
        .go_off_i     (go_off),
        .fault_i      (fault_valid_i),
        .drain_done_i (drain_done_i),
        .state_o      (state),
        .xlat_en_o    (xlat_en_o),
        .stall_o      (stall_o),
        .held_o       (held)
    );

    logic [NFAULT-1:0]        mask_q, status;
    logic [NSLOT-1:0][DW-1:0] slot_addr;

    mmu_fault_log #(.NFAULT(NFAULT), .DW(DW)) u_log (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fault_v_i    (fault_valid_i),
        .fault_type_i (fault_type_i),
        .fault_addr_i (fault_addr_i),
        .clr_we_i     (clr_we),
        .clr_bits_i   (reg_wdata_i[NFAULT-1:0]),
        .mask_i       (mask_q),
        .status_o     (status),
        .slot_addr_o  (slot_addr),
        .irq_o        (irq_o),
        .irq_type_o   (irq_type_o)
    );

    logic [DW-1:0] cfg_q, base_q, faddr_q;
    logic          fall_q, fone_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q   <= '0;
            base_q  <= '0;
            mask_q  <= '1;
            fall_q  <= 1'b0;
            fone_q  <= 1'b0;
            faddr_q <= '0;
        end else begin
            fall_q <= reg_we_i && hit(reg_addr_i, OFS_FLUSH_ALL) && reg_wdata_i[0];
            fone_q <= reg_we_i && hit(reg_addr_i, OFS_FLUSH_ONE) && reg_wdata_i[0];
            if (reg_we_i && hit(reg_addr_i, OFS_FLUSH_ONE))
                faddr_q <= {reg_wdata_i[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            if (reg_we_i && hit(reg_addr_i, OFS_CFG))  cfg_q  <= reg_wdata_i;
            if (reg_we_i && hit(reg_addr_i, OFS_BASE)) base_q <= reg_wdata_i;
            if (reg_we_i && hit(reg_addr_i, OFS_MASK)) mask_q <= reg_wdata_i[NFAULT-1:0];
        end
    end

    logic [NWIN-1:0][DW-1:0] win_lo, win_hi;

    generate
        if (HAS_WIN) begin : g_win
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    win_lo <= '0;
                    win_hi <= '0;
                end else begin
                    for (int w = 0; w < NWIN; w++) begin
                        if (reg_we_i && hit(reg_addr_i, OFS_WIN0 + WIN_STRIDE * w))
                            win_lo[w] <= reg_wdata_i;
                        if (reg_we_i && hit(reg_addr_i, OFS_WIN0 + WIN_STRIDE * w + 4))
                            win_hi[w] <= reg_wdata_i;
                    end
                end
            end
        end else begin : g_nowin
            assign win_lo = '0;
            assign win_hi = '0;
        end
    endgenerate

    function automatic logic [DW-1:0] mode_code(input mmu_state_e s);
        unique case (s)
            ST_OFF:            return DW'(CMD_OFF);
            ST_RUN:            return DW'(CMD_RUN);
            ST_DRAIN, ST_HELD: return DW'(CMD_HOLD);
        endcase
    endfunction

    always_comb begin
        reg_rdata_o = '0;
        if (hit(reg_addr_i, OFS_MODE))    reg_rdata_o = mode_code(state);
        if (hit(reg_addr_i, OFS_CFG))     reg_rdata_o = cfg_q;
        if (hit(reg_addr_i, OFS_HELD))    reg_rdata_o = DW'(held);
        if (hit(reg_addr_i, OFS_BASE))    reg_rdata_o = base_q;
        if (hit(reg_addr_i, OFS_PEND))    reg_rdata_o = DW'(status);
        if (hit(reg_addr_i, OFS_MASK))    reg_rdata_o = DW'(mask_q);
        if (hit(reg_addr_i, OFS_VERSION)) reg_rdata_o = DW'(VER_MAJOR) << (DW - 4);
        for (int s = 0; s < NSLOT; s++)
            if (hit(reg_addr_i, OFS_FADDR0 + 4 * s)) reg_rdata_o = slot_addr[s];
        for (int w = 0; w < NWIN; w++) begin
            if (hit(reg_addr_i, OFS_WIN0 + WIN_STRIDE * w))     reg_rdata_o = win_lo[w];
            if (hit(reg_addr_i, OFS_WIN0 + WIN_STRIDE * w + 4)) reg_rdata_o = win_hi[w];
        end
    end

    assign flush_all_o  = fall_q;
    assign flush_one_o  = fone_q;
    assign flush_addr_o = faddr_q;
    assign table_base_o = base_q;
    assign cfg_o        = cfg_q;
    assign pfw_start_o  = win_lo;
    assign pfw_end_o    = win_hi;

    AST_FLUSH_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_all_o || flush_one_o) |-> $past(reg_we_i && reg_wdata_i[0])); // R10
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status & mask_q) != '0); // R8

endmodule

// File: tb/mmu_ctl_regs_test.sv
module mmu_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drain_done = 1'b0;
    logic        xlat_en, stall, flush_all, flush_one;
    logic [31:0] flush_addr, table_base, cfg;
    logic        fault_v = 1'b0;
    logic [2:0]  fault_t = '0;
    logic [31:0] fault_a = '0;
    logic        irq;
    logic [2:0]  irq_type;
    logic [63:0] pfw_start, pfw_end;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mmu_ctl_regs uut (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .drain_done_i(drain_done),
        .xlat_en_o(xlat_en), .stall_o(stall), .flush_all_o(flush_all),
        .flush_one_o(flush_one), .flush_addr_o(flush_addr), .table_base_o(table_base),
        .cfg_o(cfg), .fault_valid_i(fault_v), .fault_type_i(fault_t),
        .fault_addr_i(fault_a), .irq_o(irq), .irq_type_o(irq_type),
        .pfw_start_o(pfw_start), .pfw_end_o(pfw_end)
    );

    function automatic logic [7:0] slot_reg(input logic [2:0] t);
        case (t)
            3'd0: return 8'h24;
            3'd3: return 8'h30;
            3'd1, 3'd4, 3'd5: return 8'h2C;
            default: return 8'h28;
        endcase
    endfunction

    function automatic logic [2:0] lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic flt(input logic [2:0] t, input logic [31:0] a);
        fault_v = 1'b1; fault_t = t; fault_a = a;
        @(negedge clk);
        fault_v = 1'b0;
    endtask

    logic [31:0] r;
    logic [7:0]  m_stat, m_mask;
    logic [31:0] m_slot [logic [7:0]];

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, r); chk("R1 mode", r, 0);
        rd(8'h08, r); chk("R1 held", r, 0);
        rd(8'h18, r); chk("R1 pend", r, 0);
        rd(8'h20, r); chk("R1 mask", r, 32'hFF);
        rd(8'h34, r); chk("R1 version", r, 32'h3000_0000);
        chk("R1 outputs", {29'd0, xlat_en, stall, irq}, 0);

        // R2 enable, ignored code
        wr(8'h00, 32'h3); chk("R2 ignored value", {31'd0, xlat_en}, 0);
        wr(8'h00, 32'h5); chk("R2 enable", {30'd0, xlat_en, stall}, 32'h2);
        rd(8'h00, r); chk("R2 mode readback", r, 5);

        // R3 hold and drain
        wr(8'h00, 32'h7); chk("R3 stall", {31'd0, stall}, 1);
        rd(8'h00, r); chk("R3 mode readback", r, 7);
        repeat (3) @(negedge clk);
        rd(8'h08, r); chk("R3 not held without drain", r, 0);
        drain_done = 1'b1;
        rd(8'h08, r); chk("R3 not held before edge", r, 0);
        @(negedge clk); drain_done = 1'b0;
        rd(8'h08, r); chk("R3 held after edge", r, 1);

        // R4 release
        wr(8'h00, 32'h5);
        chk("R4 release", {30'd0, xlat_en, stall}, 32'h2);
        rd(8'h08, r); chk("R4 held cleared", r, 0);

        // R5 fault stalls from run, R6 read-side slot
        flt(3'd5, 32'h1234_5678);
        chk("R5 fault stall", {31'd0, stall}, 1);
        chk("R9 type", {28'd0, irq, irq_type}, 32'hD);
        rd(8'h2C, r); chk("R6 read-side addr", r, 32'h1234_5678);
        // R5 fault together with enable keeps stall
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h5;
        fault_v = 1'b1; fault_t = 3'd1; fault_a = 32'hCAFE_0001;
        @(negedge clk); reg_we = 1'b0; fault_v = 1'b0;
        chk("R5 fault beats enable", {31'd0, stall}, 1);
        chk("R9 lowest type", {29'd0, irq_type}, 1);
        rd(8'h18, r); chk("R7 pend bits", r, 32'h22);
        drain_done = 1'b1; @(negedge clk); drain_done = 1'b0;
        rd(8'h08, r); chk("R3 held after fault", r, 1);
        wr(8'h1C, 32'hFF); chk("R7 clear drops irq", {31'd0, irq}, 0);
        wr(8'h00, 32'h5); chk("R4 release after fault", {31'd0, stall}, 0);

        // R7 same-cycle set and clear
        reg_we = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h04;
        fault_v = 1'b1; fault_t = 3'd2; fault_a = 32'h0000_BEEF;
        @(negedge clk); reg_we = 1'b0; fault_v = 1'b0;
        rd(8'h18, r); chk("R7 set wins over clear", r, 32'h04);
        rd(8'h28, r); chk("R6 write-side addr", r, 32'h0000_BEEF);
        wr(8'h1C, 32'h04);
        rd(8'h18, r); chk("R7 clear", r, 0);

        // R2 off from drain
        wr(8'h00, 32'h0);
        chk("R2 off", {30'd0, xlat_en, stall}, 0);

        // R10 flush pulses
        wr(8'h0C, 32'h1); chk("R10 flush all pulse", {31'd0, flush_all}, 1);
        @(negedge clk); chk("R10 flush all ends", {31'd0, flush_all}, 0);
        wr(8'h10, 32'hABCD_E001);
        chk("R10 flush one pulse", {31'd0, flush_one}, 1);
        chk("R10 flush addr", flush_addr, 32'hABCD_E000);
        wr(8'h0C, 32'h0); chk("R10 no pulse", {31'd0, flush_all}, 0);

        // R11 config and base
        wr(8'h04, 32'h1000_1000); wr(8'h14, 32'h8000_4000);
        rd(8'h04, r); chk("R11 cfg", r, 32'h1000_1000);
        rd(8'h14, r); chk("R11 base", r, 32'h8000_4000);
        chk("R11 outputs", table_base ^ cfg, 32'h9000_5000);

        // R12 prefetch windows
        wr(8'h4C, 32'h0010_0000); wr(8'h50, 32'h0011_FFFF);
        wr(8'h54, 32'h0020_0000); wr(8'h58, 32'h0021_FFFF);
        rd(8'h50, r); chk("R12 win0 end", r, 32'h0011_FFFF);
        rd(8'h54, r); chk("R12 win1 start", r, 32'h0020_0000);
        chk("R12 start out", pfw_start, 64'h0020_0000_0010_0000);
        chk("R12 end out", pfw_end, 64'h0021_FFFF_0011_FFFF);

        // R8 mask, R13 faults while off
        wr(8'h20, 32'h0);
        flt(3'd0, 32'h0000_0042);
        chk("R8 masked", {31'd0, irq}, 0);
        chk("R13 no stall when off", {31'd0, stall}, 0);
        rd(8'h24, r); chk("R6 page addr", r, 32'h0000_0042);
        wr(8'h20, 32'hFF);
        chk("R8 unmasked", {28'd0, irq, irq_type}, 32'h8);
        wr(8'h1C, 32'hFF);

        // Random phase against a bench model
        m_stat = 0; m_mask = 8'hFF;
        m_slot[8'h24] = 32'h42; m_slot[8'h28] = 32'hBEEF;
        m_slot[8'h2C] = 32'hCAFE_0001; m_slot[8'h30] = 0;
        r = $urandom(32'd2024);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            if (op < 2) begin
                logic [2:0] t; logic [31:0] a;
                t = 3'($urandom % 8); a = $urandom;
                flt(t, a);
                m_stat[t] = 1'b1; m_slot[slot_reg(t)] = a;
            end else if (op == 2) begin
                logic [7:0] c;
                c = 8'($urandom);
                wr(8'h1C, {24'd0, c});
                m_stat = m_stat & ~c;
            end else begin
                m_mask = 8'($urandom);
                wr(8'h20, {24'd0, m_mask});
            end
            chk("R8 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
            if (|(m_stat & m_mask))
                chk("R9 irq type", {29'd0, irq_type}, {29'd0, lowest(m_stat & m_mask)});
            rd(8'h18, r); chk("R7 pend", r, {24'd0, m_stat});
            if (it % 16 == 0) begin
                foreach (m_slot[k]) begin
                    rd(k, r); chk("R6 slot", r, m_slot[k]);
                end
            end
        end
        chk("R13 stall stays low", {31'd0, stall}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule